// File: doc/BRIEF.md
# Reservation Stations with Register Renaming and Result Broadcast

This block holds decoded instructions between in-order issue and out-of-order execution. Each incoming instruction goes to a free station of its unit type (adder, multiplier or load). For each source operand the station takes either the current register value or the tag of the station that will produce it. The destination register is then marked with the issuing station's tag. This renaming removes write-after-write and write-after-read conflicts. Issue stalls only when the needed unit has no free station.

Each station starts execution once both operand tags are zero. A per-station latency counter models the execution unit. A finished result is sent on a single result bus as a tag and a value. Every waiting station and every register whose tag matches takes the value in the same edge. When several results are ready together, the one issued first goes out and the others wait. A read port shows the value and pending tag of any architectural register.

Top module: `tomasulo_rs`

## Requirements
- R1: After reset no station is busy, no result is broadcast, every register tag is 0 and register r holds the value r.
- R2: iss_ready is high exactly when a free station exists for iss_unit (00 adder, 01 multiplier, 10 load, 11 none). An issue with iss_valid and iss_ready high takes the lowest-numbered free station of that unit. Stations are numbered with adders first, then multipliers, then loads. A station's tag is its number plus 1, and tag 0 means "no producer".
- R3: Pending RAW, WAR or WAW dependencies on the issuing instruction never lower iss_ready.
- R4: From the cycle after an issue, rd_tag of the destination register shows the tag of the issuing station.
- R5: Bit i of ready_mask is high exactly when station i is busy, has not started, and both of its operand tags are 0.
- R6: A started station broadcasts LAT cycles after the edge at which it started (LAT_ADD=2, LAT_MUL=4, LAT_LD=1). The result is: for the adder, rs1+rs2 when iss_op is 0 and rs1-rs2 when iss_op is 1; for the multiplier, the low DW bits of rs1*rs2; for a load, rs1+imm (effective address; rs2 ignored). All arithmetic is modulo 2^DW.
- R7: On a broadcast, every busy station waiting on that tag captures the value. A register captures the value and clears its tag only if its tag still equals the broadcast tag, so a later writer's rename is kept.
- R8: At most one result is broadcast per cycle. Among finished stations the earliest-issued one wins, and the others hold their results until they win.
- R9: A station is free from the cycle after its broadcast and can be issued into in that cycle.
- R10: A source whose producer broadcasts in the issue cycle is captured as that value with tag 0.
- R11: Source values copied at issue are not changed by later writes to the source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_unit | input | 2 | Unit type: 00 adder, 01 multiplier, 10 load |
| iss_op | input | 1 | Adder operation: 0 add, 1 subtract |
| iss_rd | input | RW | Destination register |
| iss_rs1 | input | RW | First source register |
| iss_rs2 | input | RW | Second source register (ignored by loads) |
| iss_imm | input | DW | Immediate / address offset |
| iss_ready | output | 1 | A station of the requested unit is free |
| ready_mask | output | N | Stations ready to start execution |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | TW | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result |
| rd_addr | input | RW | Register read address |
| rd_value | output | DW | Register file value |
| rd_tag | output | TW | Pending producer tag of the register |

## Verification
The in-design assertions check on every cycle that an issue occupies a station and renames its destination, that a station is free after its broadcast, and that a losing finished result is still broadcast in the next cycle. The bench's scenarios are needed to show the correctness of results and the oldest-first order. They also show that a stale broadcast does not overwrite a renamed register, that same-cycle forwarding takes place at issue, and that copied operands are isolated from later writes. The bench checks these by comparing against a behavioural model on every clock.

// File: rtl/tomasulo_rs.sv
module tomasulo_rs #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int NADD    = 3,
  parameter int NMUL    = 2,
  parameter int NLD     = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 4,
  parameter int LAT_LD  = 1,
  localparam int N  = NADD + NMUL + NLD,
  localparam int TW = $clog2(N + 1),
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_unit,
  input  logic          iss_op,
  input  logic [RW-1:0] iss_rd,
  input  logic [RW-1:0] iss_rs1,
  input  logic [RW-1:0] iss_rs2,
  input  logic [DW-1:0] iss_imm,
  output logic          iss_ready,
  output logic [N-1:0]  ready_mask,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_value,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_value,
  output logic [TW-1:0] rd_tag
);
  localparam int SW   = (N > 1) ? $clog2(N) : 1;
  localparam int LMAX = (LAT_ADD > LAT_MUL) ? ((LAT_ADD > LAT_LD) ? LAT_ADD : LAT_LD)
                                            : ((LAT_MUL > LAT_LD) ? LAT_MUL : LAT_LD);
  localparam int CW   = $clog2(LMAX + 1);

  function automatic logic [1:0] unit_of(input int i);
    return (i < NADD) ? 2'd0 : (i < NADD + NMUL) ? 2'd1 : 2'd2;
  endfunction

  function automatic int lat_of(input int i);
    return (i < NADD) ? LAT_ADD : (i < NADD + NMUL) ? LAT_MUL : LAT_LD;
  endfunction

  logic [N-1:0]  busy, started, done;
  logic          op    [N];
  logic [DW-1:0] vj    [N];
  logic [DW-1:0] vk    [N];
  logic [TW-1:0] qj    [N];
  logic [TW-1:0] qk    [N];
  logic [DW-1:0] aval  [N];
  logic [CW-1:0] cnt   [N];
  logic [N-1:0]  older [N];
  logic [DW-1:0] reg_val [NREG];
  logic [TW-1:0] reg_tag [NREG];

  logic          free_found, iss_fire;
  logic [SW-1:0] free_idx, win_idx;
  logic [TW-1:0] free_tag;
  logic [N-1:0]  win_oh;
  logic [DW-1:0] s1_val, s2_val;
  logic [TW-1:0] s1_tag, s2_tag;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N; i++)
      if (!busy[i] && unit_of(i) == iss_unit && !free_found) begin
        free_found = 1'b1;
        free_idx   = SW'(i);
      end
  end
  assign iss_ready = free_found;
  assign iss_fire  = iss_valid && free_found;
  assign free_tag  = TW'(free_idx) + 1'b1;

  always_comb
    for (int i = 0; i < N; i++) begin
      done[i]       = busy[i] && started[i] && cnt[i] == '0;
      ready_mask[i] = busy[i] && !started[i] && qj[i] == '0 && qk[i] == '0;
    end

  always_comb begin
    logic beaten;
    cdb_valid = 1'b0;
    win_idx   = '0;
    for (int i = 0; i < N; i++) begin
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (done[j] && older[j][i]) beaten = 1'b1;
      if (done[i] && !beaten) begin
        cdb_valid = 1'b1;
        win_idx   = SW'(i);
      end
    end
  end
  assign win_oh  = N'(1) << win_idx;
  assign cdb_tag = TW'(win_idx) + 1'b1;

  always_comb
    case (unit_of(int'(win_idx)))
      2'd0:    cdb_value = op[win_idx] ? vj[win_idx] - vk[win_idx] : vj[win_idx] + vk[win_idx];
      2'd1:    cdb_value = vj[win_idx] * vk[win_idx];
      default: cdb_value = aval[win_idx];
    endcase

  always_comb begin
    s1_tag = reg_tag[iss_rs1];
    s1_val = reg_val[iss_rs1];
    if (s1_tag != '0 && cdb_valid && cdb_tag == s1_tag) begin
      s1_tag = '0;
      s1_val = cdb_value;
    end
    s2_tag = reg_tag[iss_rs2];
    s2_val = reg_val[iss_rs2];
    if (s2_tag != '0 && cdb_valid && cdb_tag == s2_tag) begin
      s2_tag = '0;
      s2_val = cdb_value;
    end
    if (iss_unit == 2'd2) begin
      s2_tag = '0;
      s2_val = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      started <= '0;
      for (int i = 0; i < N; i++) begin
        op[i]    <= 1'b0;
        vj[i]    <= '0;
        vk[i]    <= '0;
        qj[i]    <= '0;
        qk[i]    <= '0;
        aval[i]  <= '0;
        cnt[i]   <= '0;
        older[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) begin
        reg_val[r] <= DW'(r);
        reg_tag[r] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cdb_valid && busy[i]) begin
          if (qj[i] == cdb_tag) begin vj[i] <= cdb_value; qj[i] <= '0; end
          if (qk[i] == cdb_tag) begin vk[i] <= cdb_value; qk[i] <= '0; end
        end
        if (ready_mask[i]) begin
          started[i] <= 1'b1;
          cnt[i]     <= CW'(lat_of(i) - 1);
          if (unit_of(i) == 2'd2) aval[i] <= aval[i] + vj[i];
        end else if (started[i] && cnt[i] != '0)
          cnt[i] <= cnt[i] - 1'b1;
        if (cdb_valid && win_idx == SW'(i)) begin
          busy[i]    <= 1'b0;
          started[i] <= 1'b0;
        end
      end
      for (int r = 0; r < NREG; r++)
        if (cdb_valid && reg_tag[r] == cdb_tag) begin
          reg_val[r] <= cdb_value;
          reg_tag[r] <= '0;
        end
      if (iss_fire) begin
        busy[free_idx]    <= 1'b1;
        started[free_idx] <= 1'b0;
        op[free_idx]      <= iss_op;
        vj[free_idx]      <= s1_val;
        vk[free_idx]      <= s2_val;
        qj[free_idx]      <= s1_tag;
        qk[free_idx]      <= s2_tag;
        aval[free_idx]    <= iss_imm;
        older[free_idx]   <= '0;
        for (int j = 0; j < N; j++)
          older[j][free_idx] <= busy[j];
        reg_tag[iss_rd]   <= free_tag;
      end
    end
  end

  assign rd_value = reg_val[rd_addr];
  assign rd_tag   = reg_tag[rd_addr];

  // R2
  issue_takes_station_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> busy[$past(free_idx)]);
  // R4
  dest_renamed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> reg_tag[$past(iss_rd)] == $past(free_tag));
  // R9
  freed_after_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> !busy[$past(win_idx)]);
  // R8
  loser_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (done & ~win_oh) != '0) |=> cdb_valid);
endmodule

// File: tb/test_tomasulo_rs.sv
module test_tomasulo_rs;
  localparam int NREG = 8, DW = 16, NADD = 3, NMUL = 2, NLD = 2;
  localparam int LA = 2, LM = 4, LL = 1;
  localparam int N = NADD + NMUL + NLD, TW = 3, RW = 3;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_op = 0;
  logic [1:0] iss_unit = 0;
  logic [RW-1:0] iss_rd = 0, iss_rs1 = 0, iss_rs2 = 0, rd_addr = 0;
  logic [DW-1:0] iss_imm = 0;
  logic iss_ready, cdb_valid;
  logic [N-1:0] ready_mask;
  logic [TW-1:0] cdb_tag, rd_tag;
  logic [DW-1:0] cdb_value, rd_value;

  always #10 clk = ~clk;

  tomasulo_rs #(.NREG(NREG), .DW(DW), .NADD(NADD), .NMUL(NMUL), .NLD(NLD),
                .LAT_ADD(LA), .LAT_MUL(LM), .LAT_LD(LL)) i_tomasulo_rs (.*);

  int tests = 0, fails = 0, cyc = 0, seqc = 0;
  int m_busy[N], m_op[N], m_qj[N], m_qk[N], m_go[N], m_cnt[N], m_seq[N];
  logic [DW-1:0] m_vj[N], m_vk[N], m_a[N], m_rv[NREG];
  int m_rt[NREG];

  function automatic int kind(int i);
    return (i < NADD) ? 0 : (i < NADD + NMUL) ? 1 : 2;
  endfunction
  function automatic int lat(int i);
    return (i < NADD) ? LA : (i < NADD + NMUL) ? LM : LL;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_go[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_cnt[i] = 0;
    end
    for (int r = 0; r < NREG; r++) begin m_rv[r] = DW'(r); m_rt[r] = 0; end
  endtask

  // called mid-cycle with inputs stable: compare, then advance the model over one edge
  task automatic step();
    int w, f, t1, t2;
    logic [DW-1:0] res, v1, v2;
    logic [N-1:0] mask;
    rd_addr = RW'(cyc % NREG);
    #2;
    w = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] != 0 && m_go[i] != 0 && m_cnt[i] == 0 && (w < 0 || m_seq[i] < m_seq[w])) w = i;
    res = '0;
    if (w >= 0) begin
      if (kind(w) == 0) res = (m_op[w] != 0) ? m_vj[w] - m_vk[w] : m_vj[w] + m_vk[w];
      else if (kind(w) == 1) res = m_vj[w] * m_vk[w];
      else res = m_a[w];
    end
    f = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_busy[i] == 0 && kind(i) == int'(iss_unit) && iss_unit != 2'd3) f = i;
    for (int i = 0; i < N; i++)
      mask[i] = m_busy[i] != 0 && m_go[i] == 0 && m_qj[i] == 0 && m_qk[i] == 0;
    check("R6/R8 cdb_valid", int'(cdb_valid), int'(w >= 0));
    if (w >= 0) begin
      check("R8 cdb_tag oldest first", int'(cdb_tag), w + 1);
      check("R6/R7 cdb_value", int'(cdb_value), int'(res));
    end
    check("R2/R3/R9 iss_ready", int'(iss_ready), int'(f >= 0));
    check("R5 ready_mask", int'(ready_mask), int'(mask));
    check("R4/R7/R10/R11 rd_value", int'(rd_value), int'(m_rv[rd_addr]));
    check("R4/R7 rd_tag", int'(rd_tag), m_rt[rd_addr]);
    // sources resolved before any state changes, with same-cycle forwarding
    t1 = m_rt[iss_rs1]; v1 = m_rv[iss_rs1];
    if (t1 != 0 && w >= 0 && t1 == w + 1) begin t1 = 0; v1 = res; end
    t2 = m_rt[iss_rs2]; v2 = m_rv[iss_rs2];
    if (t2 != 0 && w >= 0 && t2 == w + 1) begin t2 = 0; v2 = res; end
    if (iss_unit == 2'd2) begin t2 = 0; v2 = '0; end
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] != 0 && w >= 0) begin
        if (m_qj[i] == w + 1) begin m_vj[i] = res; m_qj[i] = 0; end
        if (m_qk[i] == w + 1) begin m_vk[i] = res; m_qk[i] = 0; end
      end
      if (mask[i]) begin
        m_go[i] = 1; m_cnt[i] = lat(i) - 1;
        if (kind(i) == 2) m_a[i] = m_a[i] + m_vj[i];
      end else if (m_go[i] != 0 && m_cnt[i] != 0) m_cnt[i]--;
      if (i == w) begin m_busy[i] = 0; m_go[i] = 0; end
    end
    for (int r = 0; r < NREG; r++)
      if (w >= 0 && m_rt[r] == w + 1) begin m_rv[r] = res; m_rt[r] = 0; end
    if (iss_valid && f >= 0) begin
      m_busy[f] = 1; m_go[f] = 0; m_op[f] = int'(iss_op);
      m_vj[f] = v1; m_vk[f] = v2; m_qj[f] = t1; m_qk[f] = t2;
      m_a[f] = iss_imm; m_seq[f] = seqc++;
      m_rt[iss_rd] = f + 1;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n);
    iss_valid = 0;
    for (int k = 0; k < n; k++) step();
  endtask

  // holds the request until a station of that unit is free
  task automatic issue(int u, int o, int d, int s1, int s2, int imm);
    bit took;
    iss_valid = 1; iss_unit = 2'(u); iss_op = 1'(o);
    iss_rd = RW'(d); iss_rs1 = RW'(s1); iss_rs2 = RW'(s2); iss_imm = DW'(imm);
    do begin
      took = iss_ready;
      step();
    end while (!took);
    iss_valid = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int lf;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    for (int r = 0; r < NREG; r++) begin
      rd_addr = RW'(r);
      #1;
      check("R1 reset rd_value", int'(rd_value), r);
      check("R1 reset rd_tag", int'(rd_tag), 0);
    end
    check("R1 reset cdb_valid", int'(cdb_valid), 0);
    check("R1 reset ready_mask", int'(ready_mask), 0);
    rst_n = 1;
    idle(2);
    // independent adds and a load; R6 result forms
    issue(0, 0, 3, 1, 2, 0);
    issue(0, 1, 4, 7, 2, 0);
    issue(2, 0, 5, 6, 0, 100);
    idle(8);
    // RAW chain through the multiplier, WAW on r0 where the younger add finishes first (R7)
    issue(1, 0, 0, 3, 4, 0);
    issue(0, 0, 6, 0, 1, 0);
    issue(0, 0, 0, 2, 2, 0);
    idle(10);
    // WAR: consumer copies r1, then r1 is rewritten (R11)
    issue(0, 0, 7, 1, 1, 0);
    issue(2, 0, 1, 2, 0, 50);
    idle(6);
    // fill the adders while they depend on a slow multiply; stall then reuse (R3, R9)
    issue(1, 0, 2, 2, 2, 0);
    issue(0, 0, 3, 2, 1, 0);
    issue(0, 1, 3, 3, 2, 0);
    issue(0, 0, 4, 3, 3, 0);
    issue(0, 0, 5, 4, 1, 0);
    idle(12);
    // several stations finishing together (R8)
    issue(0, 0, 1, 1, 1, 0);
    issue(2, 0, 2, 2, 0, 3);
    issue(2, 0, 3, 3, 0, 4);
    idle(8);
    // pseudo-random stream to create forwarding-at-issue cases (R10)
    lf = 32'h1ACE;
    for (int k = 0; k < 600; k++) begin
      lf = (lf << 1) ^ (((lf >> 31) ^ (lf >> 21) ^ (lf >> 1) ^ lf) & 1);
      if (lf[3:2] == 2'b00) idle(1);
      else issue(lf[6:5] % 3, int'(lf[7]), int'(lf[10:8]), int'(lf[13:11]), int'(lf[16:14]), int'(lf[24:17]));
    end
    idle(30);
    summary();
    $finish;
  end
endmodule